// File: doc/BRIEF.md
# Three-Wire Handshake Byte Link (Device Side)

This block sits on the controller side of a byte link to a host. The host moves bytes through an 8-bit shift register. It signals with two active-low lines: one that frames a transfer (`tip_n`) and one that toggles for each byte (`tack_n`). A direction input says which way the shift register is flowing.

When the host sends, each handshake change stores the shift-register byte into a collect buffer. When the host releases the frame line, the collected packet is handed out with its length. When the host reads, each handshake change places the next queued reply byte into the shift register. The block drives an active-low request line (`treq_n`) that tells the host reply data is waiting. While the frame line is idle, this line echoes the acknowledge line.

Every handshake event arms a delayed shift interrupt. While a host packet is being collected and its reply is still unread, a poll-suspend flag is held.

A handshake event is any change of the `tip_n`/`tack_n` pair since the previous clock. The previous levels are registered every cycle.

Top module: `hsk_byte_link`

## Requirements
- R1: During and after reset, `treq_n` is 1, `poll_block` is 0, and `sr_irq`, `sr_load` and `pkt_valid` are 0. Reset clears both buffer indices and the reply length, and cancels any pending interrupt delay.
- R2: While `tip_n`=0 and `dir_h2d`=1, each cycle in which `tip_n` or `tack_n` differs from its value at the previous clock stores `sr_in` into the collect buffer. Byte i of a packet appears at `pkt_bytes[8i+7:8i]`.
- R3: At most DEPTH bytes are collected per packet. Further handshake changes neither store a byte nor arm an interrupt, and `pkt_len` then reports DEPTH.
- R4: Storing the first byte of a packet sets `poll_block` one clock later. The flag is cleared one clock after the last reply byte is placed on `sr_out`.
- R5: While `tip_n`=0 and `dir_h2d`=0, each handshake change with unread reply bytes puts the next reply byte on `sr_out` and pulses `sr_load` for one cycle. Reply byte i is taken from `rpl_bytes[8i+7:8i]`. With no unread byte, nothing is loaded.
- R6: Loading the last reply byte drives `treq_n` to 1.
- R7: With `tip_n`=1 now and at the previous clock, a change of `tack_n` copies `tack_n` onto `treq_n`.
- R8: When `tip_n` rises and at least one byte was collected, `pkt_valid` pulses for one cycle with `pkt_len` equal to the byte count, and the collect index returns to zero. With no byte collected, there is no pulse.
- R9: `treq_n` is driven to 0 when `tip_n` rises while unread reply bytes remain. It is also driven to 0 when a non-empty reply is loaded (`rpl_load`=1) while `tip_n`=1. A reply load resets the read index to zero.
- R10: `sr_irq` pulses for one cycle exactly DELAY clocks after the cycle that armed it. A new arming before then restarts the count.
- R11: The interrupt is armed by each of these: a stored byte, a loaded reply byte, an idle acknowledge toggle, a rise of `tip_n`, and a reply load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tip_n | input | 1 | Host frame line, active low |
| tack_n | input | 1 | Host per-byte acknowledge line, active low |
| dir_h2d | input | 1 | Shift direction: 1 host-to-device, 0 device-to-host |
| sr_in | input | W | Shift-register byte written by the host |
| rpl_load | input | 1 | Load a new reply packet |
| rpl_len | input | LW | Reply length in bytes (0..DEPTH) |
| rpl_bytes | input | DEPTH*W | Reply bytes, byte i at bits [W*i+W-1:W*i] |
| sr_out | output | W | Reply byte presented to the host |
| sr_load | output | 1 | One-cycle pulse when `sr_out` takes a new byte |
| treq_n | output | 1 | Request line to the host, active low |
| poll_block | output | 1 | Unsolicited polling suspended |
| pkt_valid | output | 1 | One-cycle pulse: collected packet complete |
| pkt_len | output | LW | Length of the completed packet |
| pkt_bytes | output | DEPTH*W | Collected bytes, byte i at bits [W*i+W-1:W*i] |
| sr_irq | output | 1 | Delayed shift interrupt pulse |

## Verification
The bench builds the block with DEPTH=4 and DELAY=6 rather than 16 and 4000. With four entries, the collect buffer overflows after a handful of handshakes, so the saturation rule is reached quickly. A six-cycle delay lets both an expiring interrupt and a restarted one appear between handshake events spaced a few cycles apart.

Scenarios cover:
- back-to-back send and read-back;
- idle acknowledge toggles;
- a release with nothing collected;
- a release with reply bytes still unread.

// File: rtl/hsk_link_pkg.sv
package hsk_link_pkg;

  // Handshake observation for one clock: what changed since the previous edge.
  typedef struct packed {
    logic chg;        // tip_n or tack_n differs from previous sample
    logic tip_prev_n; // tip_n as sampled at the previous edge
    logic tack_tog;   // tack_n differs from previous sample
  } hsk_evt_t;

  function automatic int idx_bits(input int depth);
    return $clog2(depth + 1);
  endfunction

endpackage

// File: rtl/hsk_edge_track.sv
module hsk_edge_track
  import hsk_link_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     tip_n,
  input  logic     tack_n,
  output hsk_evt_t evt
);

  logic tip_q, tack_q;
  logic tip_d, tack_d;

  always_comb begin
    tip_d  = tip_n;
    tack_d = tack_n;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tip_q  <= 1'b1;
      tack_q <= 1'b1;
    end else begin
      tip_q  <= tip_d;
      tack_q <= tack_d;
    end
  end

  always_comb begin
    evt.tack_tog   = (tack_n != tack_q);
    evt.chg        = (tip_n != tip_q) || evt.tack_tog;
    evt.tip_prev_n = tip_q;
  end

endmodule

// File: rtl/hsk_collect.sv
module hsk_collect #(
  parameter int DEPTH = 16,
  parameter int W     = 8,
  parameter int LW    = $clog2(DEPTH + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               store_req,
  input  logic               rel_req,
  input  logic [W-1:0]       byte_in,
  output logic [LW-1:0]      out_idx,
  output logic               stored,
  output logic               first_store,
  output logic               pkt_valid,
  output logic [LW-1:0]      pkt_len,
  output logic [DEPTH*W-1:0] pkt_bytes
);

  localparam logic [LW-1:0] FULL = LW'(DEPTH);

  logic [LW-1:0] idx_q, idx_d;
  logic [LW-1:0] len_q, len_d;
  logic          vld_q, vld_d;
  logic [W-1:0]  mem_q [DEPTH];

  assign stored      = store_req && (idx_q < FULL);
  assign first_store = stored && (idx_q == '0);

  always_comb begin
    idx_d = idx_q;
    len_d = len_q;
    vld_d = 1'b0;
    if (stored) begin
      idx_d = idx_q + LW'(1);
    end
    if (rel_req) begin
      if (idx_q != '0) begin
        vld_d = 1'b1;
        len_d = idx_q;
      end
      idx_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q <= '0;
      len_q <= '0;
      vld_q <= 1'b0;
    end else begin
      idx_q <= idx_d;
      len_q <= len_d;
      vld_q <= vld_d;
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    logic wr_en;
    assign wr_en = stored && (idx_q == LW'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        mem_q[g] <= '0;
      end else if (wr_en) begin
        mem_q[g] <= byte_in;
      end
    end
    assign pkt_bytes[g*W +: W] = mem_q[g];
  end

  assign out_idx   = idx_q;
  assign pkt_valid = vld_q;
  assign pkt_len   = len_q;

endmodule

// File: rtl/hsk_reply.sv
module hsk_reply #(
  parameter int DEPTH = 16,
  parameter int W     = 8,
  parameter int LW    = $clog2(DEPTH + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic [LW-1:0]      load_len,
  input  logic [DEPTH*W-1:0] load_bytes,
  input  logic               tip_n,
  input  logic               tack_n,
  input  logic               feed_req,
  input  logic               sync_req,
  input  logic               rel_req,
  output logic [W-1:0]       sr_out,
  output logic               sr_load,
  output logic               treq_n,
  output logic [LW-1:0]      in_idx,
  output logic [LW-1:0]      in_len,
  output logic               fed,
  output logic               last_fed
);

  localparam int            IW   = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [LW-1:0] FULL = LW'(DEPTH);

  logic [LW-1:0] idx_q, idx_d;
  logic [LW-1:0] len_q, len_d;
  logic          treq_q, treq_d;
  logic [W-1:0]  sr_q, sr_d;
  logic          ld_q, ld_d;
  logic [W-1:0]  mem_q [DEPTH];
  logic          has_data;
  logic [LW-1:0] len_clip;

  assign has_data = (idx_q < len_q);
  assign fed      = feed_req && !load && has_data;
  assign last_fed = fed && ((idx_q + LW'(1)) == len_q);
  assign len_clip = (load_len > FULL) ? FULL : load_len;

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        mem_q[g] <= '0;
      end else if (load) begin
        mem_q[g] <= load_bytes[g*W +: W];
      end
    end
  end

  always_comb begin
    idx_d  = idx_q;
    len_d  = len_q;
    treq_d = treq_q;
    sr_d   = sr_q;
    ld_d   = 1'b0;
    if (load) begin
      len_d = len_clip;
      idx_d = '0;
      if (tip_n && (len_clip != '0)) begin
        treq_d = 1'b0;
      end
    end else if (fed) begin
      sr_d  = mem_q[idx_q[IW-1:0]];
      ld_d  = 1'b1;
      idx_d = idx_q + LW'(1);
      if (last_fed) begin
        treq_d = 1'b1;
      end
    end else if (sync_req) begin
      treq_d = tack_n;
    end else if (rel_req && has_data) begin
      treq_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q  <= '0;
      len_q  <= '0;
      treq_q <= 1'b1;
      sr_q   <= '0;
      ld_q   <= 1'b0;
    end else begin
      idx_q  <= idx_d;
      len_q  <= len_d;
      treq_q <= treq_d;
      sr_q   <= sr_d;
      ld_q   <= ld_d;
    end
  end

  assign sr_out  = sr_q;
  assign sr_load = ld_q;
  assign treq_n  = treq_q;
  assign in_idx  = idx_q;
  assign in_len  = len_q;

endmodule

// File: rtl/hsk_irq_delay.sv
module hsk_irq_delay #(
  parameter int DELAY = 4000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sched,
  output logic irq,
  output logic pend
);

  localparam int CW = (DELAY > 1) ? $clog2(DELAY) : 1;

  logic [CW-1:0] cnt_q, cnt_d;
  logic          pend_q, pend_d;
  logic          irq_q, irq_d;

  always_comb begin
    cnt_d  = cnt_q;
    pend_d = pend_q;
    irq_d  = 1'b0;
    if (sched) begin
      cnt_d  = CW'(DELAY - 1);
      pend_d = 1'b1;
    end else if (pend_q) begin
      if (cnt_q == '0) begin
        irq_d  = 1'b1;
        pend_d = 1'b0;
      end else begin
        cnt_d = cnt_q - CW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      pend_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      pend_q <= pend_d;
      irq_q  <= irq_d;
    end
  end

  assign irq  = irq_q;
  assign pend = pend_q;

endmodule

// File: rtl/hsk_byte_link.sv
module hsk_byte_link
  import hsk_link_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int W     = 8,
  parameter int DELAY = 4000,
  parameter int LW    = idx_bits(DEPTH)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tip_n,
  input  logic               tack_n,
  input  logic               dir_h2d,
  input  logic [W-1:0]       sr_in,
  input  logic               rpl_load,
  input  logic [LW-1:0]      rpl_len,
  input  logic [DEPTH*W-1:0] rpl_bytes,
  output logic [W-1:0]       sr_out,
  output logic               sr_load,
  output logic               treq_n,
  output logic               poll_block,
  output logic               pkt_valid,
  output logic [LW-1:0]      pkt_len,
  output logic [DEPTH*W-1:0] pkt_bytes,
  output logic               sr_irq
);

  hsk_evt_t      evt;
  logic          store_req, feed_req, sync_req, rel_req;
  logic          stored, first_store, fed, last_fed;
  logic [LW-1:0] out_idx, in_idx, in_len;
  logic          sched, irq_pend;
  logic          blk_q, blk_d;

  hsk_edge_track u_edge (
    .clk    (clk),
    .rst_n  (rst_n),
    .tip_n  (tip_n),
    .tack_n (tack_n),
    .evt    (evt)
  );

  // Handshake classification.
  always_comb begin
    store_req = !tip_n && dir_h2d && evt.chg;
    feed_req  = !tip_n && !dir_h2d && evt.chg;
    sync_req  = tip_n && evt.tip_prev_n && evt.tack_tog;
    rel_req   = tip_n && !evt.tip_prev_n;
  end

  hsk_collect #(.DEPTH(DEPTH), .W(W), .LW(LW)) u_col (
    .clk         (clk),
    .rst_n       (rst_n),
    .store_req   (store_req),
    .rel_req     (rel_req),
    .byte_in     (sr_in),
    .out_idx     (out_idx),
    .stored      (stored),
    .first_store (first_store),
    .pkt_valid   (pkt_valid),
    .pkt_len     (pkt_len),
    .pkt_bytes   (pkt_bytes)
  );

  hsk_reply #(.DEPTH(DEPTH), .W(W), .LW(LW)) u_rpl (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (rpl_load),
    .load_len   (rpl_len),
    .load_bytes (rpl_bytes),
    .tip_n      (tip_n),
    .tack_n     (tack_n),
    .feed_req   (feed_req),
    .sync_req   (sync_req),
    .rel_req    (rel_req),
    .sr_out     (sr_out),
    .sr_load    (sr_load),
    .treq_n     (treq_n),
    .in_idx     (in_idx),
    .in_len     (in_len),
    .fed        (fed),
    .last_fed   (last_fed)
  );

  assign sched = stored | fed | sync_req | rel_req | rpl_load;

  hsk_irq_delay #(.DELAY(DELAY)) u_irq (
    .clk   (clk),
    .rst_n (rst_n),
    .sched (sched),
    .irq   (sr_irq),
    .pend  (irq_pend)
  );

  // Poll-suspend flag: raised by the first collected byte, dropped by the last reply byte.
  always_comb begin
    blk_d = blk_q;
    if (first_store) begin
      blk_d = 1'b1;
    end else if (last_fed) begin
      blk_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      blk_q <= 1'b0;
    end else begin
      blk_q <= blk_d;
    end
  end

  assign poll_block = blk_q;

endmodule

// File: rtl/hsk_byte_link_chk.sv
module hsk_byte_link_chk #(
  parameter int DEPTH = 16,
  parameter int LW    = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          tip_n,
  input logic          dir_h2d,
  input logic          fed,
  input logic          last_fed,
  input logic          first_store,
  input logic          sr_load,
  input logic          treq_n,
  input logic          poll_block,
  input logic [LW-1:0] out_idx,
  input logic          pkt_valid,
  input logic [LW-1:0] pkt_len,
  input logic          sr_irq,
  input logic          irq_pend
);

  a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    out_idx <= LW'(DEPTH));

  a_r4_block_raise: assert property (@(posedge clk) disable iff (!rst_n)
    first_store |=> poll_block);

  a_r5_fed_dir: assert property (@(posedge clk) disable iff (!rst_n)
    fed |-> (!tip_n && !dir_h2d));

  a_r5_fed_loads: assert property (@(posedge clk) disable iff (!rst_n)
    fed |=> sr_load);

  a_r6_last_treq: assert property (@(posedge clk) disable iff (!rst_n)
    last_fed |=> treq_n);

  a_r8_len_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_valid |-> (pkt_len != '0));

  a_r10_irq_from_pend: assert property (@(posedge clk) disable iff (!rst_n)
    sr_irq |-> $past(irq_pend));

endmodule

bind hsk_byte_link hsk_byte_link_chk #(.DEPTH(DEPTH), .LW(LW)) u_chk (.*);

// File: tb/hsk_byte_link_bench.sv
module hsk_byte_link_bench;

  localparam int DEPTH = 4;
  localparam int W     = 8;
  localparam int DELAY = 6;
  localparam int LW    = $clog2(DEPTH + 1);

  logic               clk = 1'b0;
  logic               rst_n;
  logic               tip_n, tack_n, dir_h2d, rpl_load;
  logic [W-1:0]       sr_in;
  logic [LW-1:0]      rpl_len;
  logic [DEPTH*W-1:0] rpl_bytes;
  logic [W-1:0]       sr_out;
  logic               sr_load, treq_n, poll_block, pkt_valid, sr_irq;
  logic [LW-1:0]      pkt_len;
  logic [DEPTH*W-1:0] pkt_bytes;

  int checks = 0;
  int errors = 0;
  int cyc    = 0;

  always #2.5 clk = ~clk;

  hsk_byte_link #(.DEPTH(DEPTH), .W(W), .DELAY(DELAY)) u_hsk_byte_link (.*);

  // Reference model state
  int     out_q[$];
  int     rq[$];
  int     pq[$];
  bit     lt, lk;
  bit     e_treq, e_block, e_irq, e_load, e_pv;
  int     e_sr, e_plen, m_cnt;

  task automatic chk(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      out_q.delete(); rq.delete(); pq.delete();
      lt = 1; lk = 1; e_treq = 1; e_block = 0; e_irq = 0; e_load = 0;
      e_pv = 0; e_sr = 0; e_plen = 0; m_cnt = 0;
    end else begin
      bit sched, chg;
      sched = 0; e_load = 0; e_pv = 0;
      chg = (tip_n != lt) || (tack_n != lk);
      if (!tip_n && dir_h2d && chg && out_q.size() < DEPTH) begin
        if (out_q.size() == 0) e_block = 1;
        out_q.push_back(int'(sr_in));
        sched = 1;
      end
      if (tip_n && !lt) begin
        if (out_q.size() > 0) begin
          e_pv = 1; e_plen = out_q.size(); pq = out_q;
        end
        out_q.delete();
        sched = 1;
      end
      if (rpl_load) begin
        rq.delete();
        for (int i = 0; i < int'(rpl_len); i++) rq.push_back(int'(rpl_bytes[i*W +: W]));
        if (tip_n && rpl_len != 0) e_treq = 0;
        sched = 1;
      end else if (!tip_n && !dir_h2d && chg) begin
        if (rq.size() > 0) begin
          e_sr = rq.pop_front(); e_load = 1; sched = 1;
          if (rq.size() == 0) begin e_treq = 1; e_block = 0; end
        end
      end else if (tip_n && lt && tack_n != lk) begin
        e_treq = tack_n; sched = 1;
      end else if (tip_n && !lt) begin
        if (rq.size() > 0) e_treq = 0;
      end
      e_irq = 0;
      if (sched) m_cnt = DELAY;
      else if (m_cnt > 0) begin
        m_cnt--;
        if (m_cnt == 0) e_irq = 1;
      end
      lt = tip_n; lk = tack_n;
    end
  end

  // Per-clock comparison, away from the active edge.
  always @(negedge clk) begin
    if (rst_n) begin
      chk("R6 R7 R9 treq_n", treq_n, e_treq);
      chk("R4 poll_block", poll_block, e_block);
      chk("R10 R11 sr_irq", sr_irq, e_irq);
      chk("R5 sr_load", sr_load, e_load);
      if (e_load) chk("R5 sr_out", sr_out, e_sr);
      chk("R8 pkt_valid", pkt_valid, e_pv);
      if (e_pv) begin
        chk("R3 R8 pkt_len", pkt_len, e_plen);
        for (int i = 0; i < e_plen; i++) chk("R2 pkt byte", pkt_bytes[i*W +: W], pq[i]);
      end
    end
  end

  always @(posedge clk) begin
    if (cyc > 20000) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic drv(input bit t, input bit k, input bit d, input logic [W-1:0] b, input int n);
    tip_n = t; tack_n = k; dir_h2d = d; sr_in = b;
    repeat (n) @(negedge clk);
  endtask

  task automatic load_reply(input int len, input logic [DEPTH*W-1:0] bytes);
    rpl_len = LW'(len); rpl_bytes = bytes; rpl_load = 1;
    @(negedge clk);
    rpl_load = 0;
  endtask

  initial begin
    rst_n = 0; tip_n = 1; tack_n = 1; dir_h2d = 0; sr_in = 0;
    rpl_load = 0; rpl_len = 0; rpl_bytes = 0;
    repeat (4) @(negedge clk);
    // R1: reset values
    chk("R1 treq_n", treq_n, 1);
    chk("R1 poll_block", poll_block, 0);
    chk("R1 sr_irq", sr_irq, 0);
    chk("R1 pkt_valid", pkt_valid, 0);
    chk("R1 sr_load", sr_load, 0);
    rst_n = 1;
    repeat (3) @(negedge clk);

    // R2 R4: three-byte host packet, then release (R8)
    drv(0, 1, 1, 8'hA1, 8);
    chk("R4 poll_block set", poll_block, 1);
    drv(0, 0, 1, 8'hB2, 2);
    drv(0, 1, 1, 8'hC3, 9);
    drv(1, 1, 1, 8'h00, 1);
    chk("R8 pkt_valid on release", pkt_valid, 1);
    chk("R8 pkt_len", pkt_len, 3);
    repeat (8) @(negedge clk);

    // R9 R5 R6: reply loaded while idle, read back
    load_reply(3, {8'h00, 8'h33, 8'h22, 8'h11});
    chk("R9 treq low after load", treq_n, 0);
    repeat (7) @(negedge clk);
    drv(0, 1, 0, 8'h00, 3);
    drv(0, 0, 0, 8'h00, 3);
    drv(0, 1, 0, 8'h00, 1);
    chk("R6 treq high after last", treq_n, 1);
    @(negedge clk);
    chk("R4 poll_block cleared", poll_block, 0);
    drv(0, 0, 0, 8'h00, 8);   // no reply left: nothing loaded (R5)
    drv(1, 0, 0, 8'h00, 8);   // release, no bytes collected (R8)

    // R7: idle acknowledge toggles
    drv(1, 1, 0, 8'h00, 1);
    chk("R7 treq follows tack high", treq_n, 1);
    drv(1, 0, 0, 8'h00, 1);
    chk("R7 treq follows tack low", treq_n, 0);
    drv(1, 1, 0, 8'h00, 9);

    // R3: overflow beyond DEPTH
    drv(0, 1, 1, 8'h10, 2);
    drv(0, 0, 1, 8'h20, 2);
    drv(0, 1, 1, 8'h30, 2);
    drv(0, 0, 1, 8'h40, 2);
    drv(0, 1, 1, 8'h50, 2);
    drv(0, 0, 1, 8'h60, 9);
    drv(1, 0, 1, 8'h00, 1);
    chk("R3 pkt_len saturates", pkt_len, DEPTH);
    repeat (8) @(negedge clk);

    // R9: release with unread reply data
    load_reply(2, {16'h0, 8'h99, 8'h88});
    drv(0, 0, 0, 8'h00, 3);
    drv(0, 1, 0, 8'h00, 3);
    load_reply(2, {16'h0, 8'h77, 8'h66});
    drv(1, 1, 0, 8'h00, 1);
    chk("R9 treq low on release with data", treq_n, 0);
    drv(1, 0, 0, 8'h00, 2);
    drv(1, 1, 0, 8'h00, 10);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule